// File: doc/BRIEF.md
# Descriptor Queue Manager

The block holds descriptor pointers in a large set of independent hardware FIFO queues. A register bus pushes a descriptor by writing its address to a queue's data register, and pops the queue head by reading that same register. Each queue is a linked list of descriptor indices. Head and tail pointers are kept per queue, and the next-pointers sit in one linking RAM that has one slot per descriptor. A packed pending bitmap shows which queues hold entries.

One descriptor region is configured by a base address and a control word. The control word gives the first slot index, a size code and a count code. Every pushed address is turned into a slot index through this region. A pop turns the slot index back into an address. The low five bits of a push word carry a size hint, which is kept per slot and returned with the pop. A push into an empty completion queue raises a completion status bit, and that bit drives the interrupt output through an enable mask.

Top module: `desc_queue_mgr`

## Requirements
- R1: After reset every queue is empty, all pending words and the status register read 0, and `irq_o` is low.
- R2: A write to byte address 0x2000 + 16·q + 0xC pushes into queue q. A read of that address pops queue q in FIFO order. Queues are independent of each other.
- R3: A popped word carries the descriptor address in bits 31:5 and returns in bits 4:0 the hint that was pushed with it.
- R4: A pop from an empty queue returns 0 and changes no queue state.
- R5: The pending word at byte address 0x90 + 4·w has bit b set exactly while queue 32·w + b holds at least one entry.
- R6: The region base is at 0x1000 and the control word at 0x1004. The control word holds the first slot index in bits 31:16, the size code (descriptor bytes = 32 << code) in bits 11:8 and the count code (descriptor count = 32 << code) in bits 4:0. A push is accepted only when base ≤ address < base + count·size and first index + (address − base)/size < NUM_DESC.
- R7: A push that fails R6 is dropped and sets status bit 0. The bit stays set until it is cleared.
- R8: A push into an empty queue numbered COMP_FIRST..COMP_LAST sets status bit 2. A push into any other queue, or into a queue that already holds entries, does not set it.
- R9: `irq_o` is high exactly when a status bit (address 0x0) is set and its bit in the enable register (address 0x4) is also set.
- R10: A write to the status register clears the bits that are 1 in the written value and leaves the other bits unchanged.
- R11: The linking-RAM base (0x80) and size (0x84) registers read back the values written to them.
- R12: Every read request is answered with `rsp_valid` high on the next cycle. Queue registers at offsets 0x0, 0x4 and 0x8 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 1 | Completion/error interrupt |

## Verification
The assertions assume at most one bus operation per cycle, so a push and a pop never coincide. They also assume that a descriptor is not pushed again while it is still linked in some queue, because the linked lists would otherwise corrupt each other. The stimulus issues each request as a single-cycle strobe. It pushes only descriptor-aligned addresses, and a descriptor is pushed again only after it has been popped. Out-of-region pushes are aimed below the base, past the region span and past the end of the linking RAM.

// File: rtl/dqm_pkg.sv
package dqm_pkg;
  localparam logic [15:0] A_STAT  = 16'h0000;
  localparam logic [15:0] A_EN    = 16'h0004;
  localparam logic [15:0] A_LBASE = 16'h0080;
  localparam logic [15:0] A_LSIZE = 16'h0084;
  localparam logic [15:0] A_PEND  = 16'h0090;
  localparam logic [15:0] A_RBASE = 16'h1000;
  localparam logic [15:0] A_RCTRL = 16'h1004;
  localparam logic [15:0] A_QBASE = 16'h2000;

  localparam int STAT_ERR  = 0;
  localparam int STAT_COMP = 2;

  typedef struct packed {
    logic        ok;
    logic [31:0] idx;
  } xlate_t;

  // log2 of descriptor bytes from the size code
  function automatic int unsigned desc_shift(input logic [3:0] sz);
    return 32'(sz) + 32'd5;
  endfunction

  // address -> slot index, with range checks against the region
  function automatic xlate_t addr_to_slot(input logic [31:0] addr,
                                          input logic [31:0] base,
                                          input logic [31:0] ctrl,
                                          input int unsigned ndesc);
    xlate_t r;
    int unsigned sh;
    int unsigned span_log;
    logic [63:0] off;
    logic [63:0] gidx;
    sh       = desc_shift(ctrl[11:8]);
    span_log = 32'(ctrl[4:0]) + 32'd5 + sh;
    off      = 64'(addr) - 64'(base);
    gidx     = (off >> sh) + 64'(ctrl[31:16]);
    r.ok     = (addr >= base) && ((off >> span_log) == 64'd0) && (gidx < 64'(ndesc));
    r.idx    = gidx[31:0];
    return r;
  endfunction

  // slot index -> 32-byte aligned descriptor address
  function automatic logic [31:0] slot_to_addr(input logic [31:0] idx,
                                               input logic [31:0] base,
                                               input logic [31:0] ctrl);
    logic [31:0] a;
    a = base + ((idx - 32'(ctrl[31:16])) << desc_shift(ctrl[11:8]));
    return a & ~32'h1F;
  endfunction
endpackage

// File: rtl/dqm_bus_decode.sv
module dqm_bus_decode #(
  parameter int NUM_QUEUES = 160,
  parameter int PEND_WORDS = 5,
  parameter int QW         = 8,
  parameter int PIW        = 3
) (
  input  logic [15:0]    addr,
  output logic           is_qdata,
  output logic           is_qother,
  output logic [QW-1:0]  q_num,
  output logic           is_pend,
  output logic [PIW-1:0] pend_idx,
  output logic           is_stat,
  output logic           is_en,
  output logic           is_lbase,
  output logic           is_lsize,
  output logic           is_rbase,
  output logic           is_rctrl
);
  import dqm_pkg::*;
  logic [15:0] qoff;
  logic [15:0] poff;
  logic        in_qspace;

  always_comb begin
    qoff      = addr - A_QBASE;
    poff      = addr - A_PEND;
    in_qspace = (addr >= A_QBASE) && (32'(qoff) < 32'(NUM_QUEUES) * 32'd16);
    q_num     = QW'(qoff >> 4);
    is_qdata  = in_qspace && (qoff[3:0] == 4'hC);
    is_qother = in_qspace && (qoff[3:0] != 4'hC);
    is_pend   = (addr >= A_PEND) && (32'(poff) < 32'(PEND_WORDS) * 32'd4) && (poff[1:0] == 2'b00);
    pend_idx  = PIW'(poff >> 2);
    is_stat   = (addr == A_STAT);
    is_en     = (addr == A_EN);
    is_lbase  = (addr == A_LBASE);
    is_lsize  = (addr == A_LSIZE);
    is_rbase  = (addr == A_RBASE);
    is_rctrl  = (addr == A_RCTRL);
  end
endmodule

// File: rtl/dqm_region.sv
module dqm_region #(
  parameter int NUM_DESC = 128,
  parameter int IW       = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_base,
  input  logic          wr_ctrl,
  input  logic [31:0]   wdata,
  input  logic [31:0]   push_word,
  input  logic [IW-1:0] pop_idx,
  output logic [31:0]   base_q,
  output logic [31:0]   ctrl_q,
  output logic          tr_ok,
  output logic [IW-1:0] tr_idx,
  output logic [31:0]   pop_addr
);
  import dqm_pkg::*;
  xlate_t xl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_base) base_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata;
    end
  end

  always_comb begin
    xl       = addr_to_slot({push_word[31:5], 5'b0}, base_q, ctrl_q, NUM_DESC);
    tr_ok    = xl.ok;
    tr_idx   = IW'(xl.idx);
    pop_addr = slot_to_addr(32'(pop_idx), base_q, ctrl_q);
  end
endmodule

// File: rtl/dqm_queue_store.sv
module dqm_queue_store #(
  parameter int NUM_QUEUES = 160,
  parameter int NUM_DESC   = 128,
  parameter int QW         = 8,
  parameter int IW         = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push_en,
  input  logic [QW-1:0]         push_q,
  input  logic [IW-1:0]         push_idx,
  input  logic [4:0]            push_hint,
  input  logic                  pop_en,
  input  logic [QW-1:0]         pop_q,
  output logic                  pop_hit,
  output logic [IW-1:0]         pop_idx,
  output logic [4:0]            pop_hint,
  output logic                  push_to_empty,
  output logic [NUM_QUEUES-1:0] pend
);
  logic [NUM_QUEUES-1:0] busy;
  logic [IW-1:0] head [NUM_QUEUES];
  logic [IW-1:0] tail [NUM_QUEUES];
  logic [IW-1:0] nxt  [NUM_DESC];
  logic [4:0]    hint_mem [NUM_DESC];
  logic          pop_empty;
  logic          pop_last;

  assign pop_hit       = pop_en && busy[pop_q];
  assign pop_empty     = pop_en && !busy[pop_q];
  assign pop_idx       = head[pop_q];
  assign pop_hint      = hint_mem[head[pop_q]];
  assign pop_last      = head[pop_q] == tail[pop_q];
  assign push_to_empty = push_en && !busy[push_q];
  assign pend          = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
    end else if (push_en) begin
      busy[push_q] <= 1'b1;
    end else if (pop_hit && pop_last) begin
      busy[pop_q] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push_en) begin
      hint_mem[push_idx] <= push_hint;
      tail[push_q]       <= push_idx;
      if (busy[push_q]) nxt[tail[push_q]] <= push_idx;
      else              head[push_q]      <= push_idx;
    end else if (pop_hit && !pop_last) begin
      head[pop_q] <= nxt[head[pop_q]];
    end
  end

  assert_one_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_en && pop_en));
  assert_push_sets_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> pend[$past(push_q)]);
  assert_empty_pop_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_empty |=> $stable(pend));
  assert_pop_last_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_hit && pop_last) |=> !pend[$past(pop_q)]);
endmodule

// File: rtl/dqm_irq_ctrl.sv
module dqm_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_comp,
  input  logic       evt_err,
  input  logic       wr_stat,
  input  logic       wr_en,
  input  logic [2:0] wbits,
  output logic [2:0] stat_q,
  output logic [2:0] en_q,
  output logic       irq_o
);
  import dqm_pkg::*;
  logic [2:0] set_bits;
  logic [2:0] clr_bits;

  always_comb begin
    set_bits            = '0;
    set_bits[STAT_ERR]  = evt_err;
    set_bits[STAT_COMP] = evt_comp;
    clr_bits            = wr_stat ? wbits : 3'b000;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | set_bits;
      if (wr_en) en_q <= wbits;
    end
  end

  assign irq_o = |(stat_q & en_q);

  assert_comp_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_comp |=> stat_q[STAT_COMP]);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[STAT_ERR] && !(wr_stat && wbits[STAT_ERR])) |=> stat_q[STAT_ERR]);
  assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wbits[STAT_COMP] && !evt_comp) |=> !stat_q[STAT_COMP]);
endmodule

// File: rtl/desc_queue_mgr.sv
module desc_queue_mgr #(
  parameter int NUM_QUEUES = 160,
  parameter int NUM_DESC   = 128,
  parameter int COMP_FIRST = 93,
  parameter int COMP_LAST  = 155
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        irq_o
);
  localparam int QW         = $clog2(NUM_QUEUES);
  localparam int IW         = $clog2(NUM_DESC);
  localparam int PEND_WORDS = (NUM_QUEUES + 31) / 32;
  localparam int PIW        = (PEND_WORDS > 1) ? $clog2(PEND_WORDS) : 1;

  logic wr, rd;
  logic is_qdata, is_qother, is_pend, is_stat, is_en, is_lbase, is_lsize, is_rbase, is_rctrl;
  logic [QW-1:0]  q_num;
  logic [PIW-1:0] pend_idx;
  logic [31:0] lbase_q, lsize_q, rbase_q, rctrl_q, pop_addr;
  logic        tr_ok;
  logic [IW-1:0] tr_idx, pop_idx;
  logic [4:0]  pop_hint;
  logic        push_en, push_err, pop_en, pop_hit, push_to_empty, comp_evt, q_in_comp;
  logic [NUM_QUEUES-1:0]    pend;
  logic [PEND_WORDS*32-1:0] pend_ext;
  logic [2:0]  stat_q, en_q;
  logic [31:0] rdata_d;

  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  dqm_bus_decode #(.NUM_QUEUES(NUM_QUEUES), .PEND_WORDS(PEND_WORDS), .QW(QW), .PIW(PIW)) u_dec (
    .addr(req_addr), .is_qdata(is_qdata), .is_qother(is_qother), .q_num(q_num),
    .is_pend(is_pend), .pend_idx(pend_idx), .is_stat(is_stat), .is_en(is_en),
    .is_lbase(is_lbase), .is_lsize(is_lsize), .is_rbase(is_rbase), .is_rctrl(is_rctrl)
  );

  dqm_region #(.NUM_DESC(NUM_DESC), .IW(IW)) u_region (
    .clk(clk), .rst_n(rst_n), .wr_base(wr && is_rbase), .wr_ctrl(wr && is_rctrl),
    .wdata(req_wdata), .push_word(req_wdata), .pop_idx(pop_idx),
    .base_q(rbase_q), .ctrl_q(rctrl_q), .tr_ok(tr_ok), .tr_idx(tr_idx), .pop_addr(pop_addr)
  );

  assign push_en  = wr && is_qdata && tr_ok;
  assign push_err = wr && is_qdata && !tr_ok;
  assign pop_en   = rd && is_qdata;

  dqm_queue_store #(.NUM_QUEUES(NUM_QUEUES), .NUM_DESC(NUM_DESC), .QW(QW), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_q(q_num), .push_idx(tr_idx),
    .push_hint(req_wdata[4:0]), .pop_en(pop_en), .pop_q(q_num), .pop_hit(pop_hit),
    .pop_idx(pop_idx), .pop_hint(pop_hint), .push_to_empty(push_to_empty), .pend(pend)
  );

  assign q_in_comp = (32'(q_num) >= 32'(COMP_FIRST)) && (32'(q_num) <= 32'(COMP_LAST));
  assign comp_evt  = push_to_empty && q_in_comp;

  dqm_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .evt_comp(comp_evt), .evt_err(push_err),
    .wr_stat(wr && is_stat), .wr_en(wr && is_en), .wbits(req_wdata[2:0]),
    .stat_q(stat_q), .en_q(en_q), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lbase_q <= '0;
      lsize_q <= '0;
    end else begin
      if (wr && is_lbase) lbase_q <= req_wdata;
      if (wr && is_lsize) lsize_q <= req_wdata;
    end
  end

  assign pend_ext = (PEND_WORDS*32)'(pend);

  always_comb begin
    rdata_d = '0;
    if (is_qdata)       rdata_d = pop_hit ? (pop_addr | 32'(pop_hint)) : 32'd0;
    else if (is_qother) rdata_d = '0;
    else if (is_pend)   rdata_d = pend_ext[32*pend_idx +: 32];
    else if (is_stat)   rdata_d = {29'b0, stat_q};
    else if (is_en)     rdata_d = {29'b0, en_q};
    else if (is_lbase)  rdata_d = lbase_q;
    else if (is_lsize)  rdata_d = lsize_q;
    else if (is_rbase)  rdata_d = rbase_q;
    else if (is_rctrl)  rdata_d = rctrl_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rdata_d : 32'd0;
    end
  end

  assert_read_answered_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  assert_dropped_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_err |=> ($stable(pend) && stat_q[0]));
  assert_empty_pop_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !pop_hit) |=> (rsp_rdata == 32'd0));
endmodule

// File: tb/tb_desc_queue_mgr.sv
module tb_desc_queue_mgr;
  localparam int NQ = 160;
  localparam logic [31:0] BASE = 32'h8000_0000;
  localparam logic [31:0] HINT = 32'd10; // (64 - 24) / 4

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, irq_o;
  logic [31:0] rsp_rdata;
  int n_chk = 0, n_bad = 0;
  logic [31:0] model [NQ][$];
  logic [31:0] exp_val [$];
  string       exp_tag [$];
  logic        done = 0;

  always #5 clk = ~clk;

  desc_queue_mgr dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_o(irq_o));

  function automatic logic [15:0] qaddr(input int q);
    return 16'(32'h2000 + q * 16 + 12);
  endfunction

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); #1 req_valid = 0; req_write = 0;
  endtask

  task automatic bus_read(input logic [15:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    exp_val.push_back(e); exp_tag.push_back(tag);
    @(posedge clk); #1 req_valid = 0;
  endtask

  // monitor: compare responses against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_chk++;
      if (exp_val.size() == 0) begin
        n_bad++; $display("FAIL R12 unexpected response act=%h exp=none", rsp_rdata);
      end else begin
        logic [31:0] e; string t;
        e = exp_val.pop_front(); t = exp_tag.pop_front();
        if (rsp_rdata !== e) begin
          n_bad++; $display("FAIL %s act=%h exp=%h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    n_chk++;
    if (irq_o !== e) begin n_bad++; $display("FAIL %s irq act=%b exp=%b", tag, irq_o, e); end
  endtask

  task automatic push(input int q, input int slot, input bit ok);
    logic [31:0] w;
    w = BASE + 32'(slot) * 64 + HINT;
    bus_write(qaddr(q), w);
    if (ok) model[q].push_back(w);
  endtask

  task automatic pop_chk(input int q, input string tag);
    logic [31:0] e;
    e = (model[q].size() > 0) ? model[q].pop_front() : 32'd0;
    bus_read(qaddr(q), e, tag);
  endtask

  task automatic pend_chk(input string tag);
    for (int w = 0; w < 5; w++) begin
      logic [31:0] e;
      e = 0;
      for (int b = 0; b < 32; b++) if (model[w*32+b].size() > 0) e[b] = 1'b1;
      bus_read(16'(32'h90 + 4*w), e, tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk_irq(0, "R1 reset");
    pend_chk("R1 pending after reset");
    bus_read(16'h0000, 0, "R1 status after reset");
    // R11 linking RAM registers
    bus_write(16'h0080, 32'h1234_5600);
    bus_write(16'h0084, 32'd512);
    bus_read(16'h0080, 32'h1234_5600, "R11 link base");
    bus_read(16'h0084, 32'd512, "R11 link size");
    // R6 region: 64-byte descriptors, 128 of them, first slot 0
    bus_write(16'h1000, BASE);
    bus_write(16'h1004, (32'd1 << 8) | 32'd2);
    bus_read(16'h1004, (32'd1 << 8) | 32'd2, "R6 ctrl readback");
    // R2 interleaved pushes to two queues
    push(5, 0, 1); push(40, 1, 1); push(5, 2, 1); push(40, 3, 1); push(5, 127, 1);
    pend_chk("R5 pending with q5 and q40");
    bus_read(16'h2050, 0, "R12 queue reg offset 0 reads 0");
    pop_chk(5, "R2 q5 first");
    pop_chk(40, "R2 q40 first");
    pop_chk(5, "R3 q5 second word and hint");
    pop_chk(5, "R6 q5 last slot of region");
    pop_chk(5, "R4 q5 empty pop");
    pop_chk(40, "R2 q40 second");
    pend_chk("R4 pending after draining");
    bus_read(16'h0000, 0, "R8 no completion from q5/q40");
    // R7 out-of-region pushes
    bus_write(qaddr(7), BASE - 32'd64 + HINT);
    bus_write(qaddr(7), BASE + 32'd128 * 64 + HINT);
    pend_chk("R7 dropped pushes leave queues empty");
    bus_read(16'h0000, 32'h1, "R7 error bit set");
    // R9 error bit masked while only completion enabled
    bus_write(16'h0004, 32'h4);
    chk_irq(0, "R9 error masked");
    // R8 completion queue
    push(100, 9, 1);
    chk_irq(1, "R9 completion enabled");
    bus_read(16'h0000, 32'h5, "R8 completion bit");
    // R10 clear completion only
    bus_write(16'h0000, 32'h4);
    chk_irq(0, "R10 completion cleared");
    bus_read(16'h0000, 32'h1, "R10 error kept");
    push(100, 10, 1);
    bus_read(16'h0000, 32'h1, "R8 push to non-empty completion queue");
    push(20, 11, 1);
    bus_read(16'h0000, 32'h1, "R8 push outside completion range");
    bus_write(16'h0004, 32'h1);
    chk_irq(1, "R9 error enabled");
    bus_write(16'h0000, 32'h1);
    chk_irq(0, "R10 error cleared");
    pop_chk(100, "R2 q100 first");
    pop_chk(100, "R2 q100 second");
    pop_chk(20, "R2 q20");
    // R6 first slot index 120: slot 7 maps to 127, slot 8 overflows
    bus_write(16'h1004, (32'd120 << 16) | (32'd1 << 8) | 32'd2);
    push(3, 8, 0);
    bus_read(16'h0000, 32'h1, "R7 slot past linking RAM");
    push(3, 7, 1);
    push(3, 0, 1);
    pend_chk("R5 pending with q3");
    pop_chk(3, "R6 offset slot 127");
    pop_chk(3, "R6 offset slot 120");
    pop_chk(3, "R4 q3 empty");
    repeat (4) @(negedge clk);
    if (exp_val.size() != 0) begin
      n_bad++; $display("FAIL R12 missing responses act=%0d exp=0", exp_val.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule